// File: doc/BRIEF.md
# Two-Cell Sample Memory Manager

This block runs one channel's small analog sample memory, a bank of two cells that each freeze a time and a charge sample. Cells are used strictly first-in, first-out. A write machine watches the channel's trigger. On a hit it freezes the next free cell and stores the coarse timestamp of that moment next to it. A separate read machine offers the oldest frozen cell to a shared converter through a request/acknowledge handshake. It lets the cell go back to tracking only once the converter reports the conversion finished.

The coarse timestamp comes from a slower counter in another clock domain and arrives Gray-coded. The block resynchronizes it and decodes it to binary before capturing it. A hit that finds every cell occupied is dropped and counted in a saturating counter. Each channel gets its own copy of this block, and no state is shared between channels.

Top module: `cell_fifo_mgr`

## Requirements
- R1: After reset, all hold outputs are 0, `full_o` and `conv_req_o` are 0, `lost_o` is 0, and both `wr_sel_o` and `rd_sel_o` are 0.
- R2: A hit is accepted when `trig_i` is high, the write machine is armed and fewer than `NCELL` cells are occupied before the edge. On acceptance, bit `wr_sel_o` of `hold_o` becomes 1 and `wr_sel_o` advances by one, wrapping from `NCELL-1` to 0.
- R3: A trigger held high for many cycles counts as one hit. The write machine re-arms only after `trig_i` has been sampled low.
- R4: The timestamp stored with a cell is the binary decode of `ts_gray_i`, provided that input was stable for at least 3 clock cycles before the accepting edge. It appears on `conv_ts_o` while that cell is being converted.
- R5: Cells are converted in the order their hits were accepted. `rd_sel_o` names the cell under conversion and advances by one, with wrap, after each conversion.
- R6: `conv_req_o` rises when at least one cell is occupied and the read machine is idle. It stays high until `conv_ack_i` is sampled high and is low in the following cycle. The cell's hold bit stays 1 until `conv_done_i` is sampled after the acknowledge, and is 0 in the cycle after that.
- R7: `full_o` is 1 exactly when all `NCELL` hold bits are 1.
- R8: A hit that finds every cell occupied leaves `hold_o` and `wr_sel_o` unchanged and increments `lost_o`. `lost_o` saturates at 2^`LOST_W`-1.
- R9: When a hit is accepted on the same edge that a conversion completes, the occupancy is unchanged overall. One hold bit clears, one sets, and `full_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-management clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Channel trigger, level, one hit per rising level |
| ts_gray_i | input | TS_W | Gray-coded coarse timestamp from the slower domain |
| conv_ack_i | input | 1 | Converter accepts the current request |
| conv_done_i | input | 1 | Converter has finished the accepted cell |
| hold_o | output | NCELL | Per-cell freeze control, 1 = cell holds a sample |
| wr_sel_o | output | PTR_W | Cell that the next hit will freeze |
| rd_sel_o | output | PTR_W | Cell routed to the converter |
| conv_req_o | output | 1 | Conversion request |
| conv_ts_o | output | TS_W | Timestamp of the cell on `rd_sel_o` |
| full_o | output | 1 | All cells occupied |
| lost_o | output | LOST_W | Saturating count of dropped hits |

## Verification
The bench builds the block with two cells, an 8-bit timestamp and a 3-bit lost counter. With an 8-bit timestamp it can sweep all 256 Gray codes through the synchronizer, capture each one in a hit, and read it back during conversion, so every cell index is hit many times over. The 3-bit counter lets ten dropped hits drive it into saturation. With two cells, full, drop and the case where a hit and a release land on the same edge can all be set up directly.

// File: rtl/cell_fifo_pkg.sv
// Shared state encodings for the two-cell sample memory manager.
package cell_fifo_pkg;
    typedef enum logic {
        W_ARM,
        W_RELEASE
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_REQ,
        R_CONV
    } rd_state_t;
endpackage

// File: rtl/ts_gray_sync.sv
// Brings a Gray-coded counter value from a slower clock domain into clk
// through two flops, then decodes it to binary.
// Assumes the source changes by at most one bit per source clock.
module ts_gray_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // two-stage synchronizer on the Gray bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_i;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it
    always_comb begin
        bin_o[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/hit_writer.sv
// Write machine: accepts one hit per trigger level and points at the next
// free cell. Counts hits that find the memory full, saturating.
// Assumes full_i reflects occupancy before the current edge.
module hit_writer
    import cell_fifo_pkg::*;
#(
    parameter int NCELL  = 2,
    parameter int LOST_W = 8,
    parameter int PTR_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              full_i,
    output logic              push_o,
    output logic [PTR_W-1:0]  wptr_o,
    output logic [LOST_W-1:0] lost_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NCELL - 1);

    wr_state_t state_q;
    logic      hit;

    assign hit    = (state_q == W_ARM) && trig_i;
    assign push_o = hit && !full_i;

    // arm / wait-for-release sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_ARM;
        end else if (state_q == W_ARM) begin
            if (trig_i) state_q <= W_RELEASE;
        end else if (!trig_i) begin
            state_q <= W_ARM;
        end
    end

    // write pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_o <= '0;
        end else if (push_o) begin
            wptr_o <= (wptr_o == LAST) ? '0 : wptr_o + 1'b1;
        end
    end

    // saturating count of dropped hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_o <= '0;
        end else if (hit && full_i && (lost_o != '1)) begin
            lost_o <= lost_o + 1'b1;
        end
    end
endmodule

// File: rtl/conv_reader.sv
// Read machine: requests a conversion for the oldest occupied cell, waits
// for acknowledge, then for done, and only then releases the cell.
module conv_reader
    import cell_fifo_pkg::*;
#(
    parameter int NCELL = 2,
    parameter int PTR_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             occupied_i,
    input  logic             conv_ack_i,
    input  logic             conv_done_i,
    output logic             pop_o,
    output logic             conv_req_o,
    output logic [PTR_W-1:0] rptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NCELL - 1);

    rd_state_t state_q;

    assign conv_req_o = (state_q == R_REQ);
    assign pop_o      = (state_q == R_CONV) && conv_done_i;

    // idle -> request -> converting -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            unique case (state_q)
                R_IDLE:  if (occupied_i) state_q <= R_REQ;
                R_REQ:   if (conv_ack_i) state_q <= R_CONV;
                R_CONV:  if (conv_done_i) state_q <= R_IDLE;
                default: state_q <= R_IDLE;
            endcase
        end
    end

    // read pointer advance with wrap on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_o <= '0;
        end else if (pop_o) begin
            rptr_o <= (rptr_o == LAST) ? '0 : rptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/cell_bank.sv
// Per-cell hold flags and captured timestamps. Assumes a push and a pop
// never address the same cell on one edge (guaranteed by occupancy).
module cell_bank #(
    parameter int NCELL = 2,
    parameter int TS_W  = 24,
    parameter int PTR_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [PTR_W-1:0] wptr_i,
    input  logic             pop_i,
    input  logic [PTR_W-1:0] rptr_i,
    input  logic [TS_W-1:0]  ts_i,
    output logic [NCELL-1:0] hold_o,
    output logic [TS_W-1:0]  ts_rd_o
);
    logic [TS_W-1:0] ts_q [NCELL];

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        // freeze on push with timestamp capture, release on pop
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_o[c] <= 1'b0;
                ts_q[c]   <= '0;
            end else if (push_i && (wptr_i == PTR_W'(c))) begin
                hold_o[c] <= 1'b1;
                ts_q[c]   <= ts_i;
            end else if (pop_i && (rptr_i == PTR_W'(c))) begin
                hold_o[c] <= 1'b0;
            end
        end
    end

    assign ts_rd_o = ts_q[rptr_i];
endmodule

// File: rtl/cell_fifo_mgr.sv
// Top: one channel's FIFO-ordered sample memory with independent write and
// read machines and a per-cell coarse timestamp.
// Assumes ts_gray_i is Gray-coded and stable >= 3 cycles around a hit.
module cell_fifo_mgr #(
    parameter int NCELL  = 2,
    parameter int TS_W   = 24,
    parameter int LOST_W = 8,
    localparam int PTR_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [TS_W-1:0]   ts_gray_i,
    input  logic              conv_ack_i,
    input  logic              conv_done_i,
    output logic [NCELL-1:0]  hold_o,
    output logic [PTR_W-1:0]  wr_sel_o,
    output logic [PTR_W-1:0]  rd_sel_o,
    output logic              conv_req_o,
    output logic [TS_W-1:0]   conv_ts_o,
    output logic              full_o,
    output logic [LOST_W-1:0] lost_o
);
    localparam int CNT_W = $clog2(NCELL + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NCELL);

    logic [TS_W-1:0]  ts_bin;
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] occ_q;

    assign full_o = (occ_q == CNT_MAX);

    ts_gray_sync #(.W(TS_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_i (ts_gray_i),
        .bin_o  (ts_bin)
    );

    hit_writer #(.NCELL(NCELL), .LOST_W(LOST_W), .PTR_W(PTR_W)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .full_i (full_o),
        .push_o (push),
        .wptr_o (wr_sel_o),
        .lost_o (lost_o)
    );

    conv_reader #(.NCELL(NCELL), .PTR_W(PTR_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .occupied_i  (occ_q != '0),
        .conv_ack_i  (conv_ack_i),
        .conv_done_i (conv_done_i),
        .pop_o       (pop),
        .conv_req_o  (conv_req_o),
        .rptr_o      (rd_sel_o)
    );

    cell_bank #(.NCELL(NCELL), .TS_W(TS_W), .PTR_W(PTR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wptr_i  (wr_sel_o),
        .pop_i   (pop),
        .rptr_i  (rd_sel_o),
        .ts_i    (ts_bin),
        .hold_o  (hold_o),
        .ts_rd_o (conv_ts_o)
    );

    // occupancy count, push and pop on one edge cancel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/cell_fifo_mgr_chk.sv
// Protocol and occupancy properties for cell_fifo_mgr, bound to every instance.
module cell_fifo_mgr_chk #(
    parameter int NCELL  = 2,
    parameter int LOST_W = 8,
    parameter int PTR_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic              conv_ack_i,
    input logic              conv_done_i,
    input logic [NCELL-1:0]  hold_o,
    input logic [PTR_W-1:0]  wr_sel_o,
    input logic [PTR_W-1:0]  rd_sel_o,
    input logic              conv_req_o,
    input logic              full_o,
    input logic [LOST_W-1:0] lost_o
);
    p_wr_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_sel_o) |-> $past(trig_i && !full_o));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && !conv_ack_i |=> conv_req_o);

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && conv_ack_i |=> !conv_req_o);

    p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_sel_o) |-> $past(conv_done_i));

    p_full_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == ($countones(hold_o) == NCELL));

    p_lost_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lost_o) |-> (lost_o == LOST_W'($past(lost_o) + 1'b1)) && $past(full_o));

    p_lost_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o == '1 |=> lost_o == '1);
endmodule

bind cell_fifo_mgr cell_fifo_mgr_chk #(.NCELL(NCELL), .LOST_W(LOST_W), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .conv_ack_i  (conv_ack_i),
    .conv_done_i (conv_done_i),
    .hold_o      (hold_o),
    .wr_sel_o    (wr_sel_o),
    .rd_sel_o    (rd_sel_o),
    .conv_req_o  (conv_req_o),
    .full_o      (full_o),
    .lost_o      (lost_o)
);

// File: tb/test_cell_fifo_mgr.sv
// Bench: two cells, 8-bit timestamp, 3-bit lost counter.
module test_cell_fifo_mgr;
    localparam int NCELL  = 2;
    localparam int TS_W   = 8;
    localparam int LOST_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig = 1'b0;
    logic [TS_W-1:0]   ts_gray = '0;
    logic              ack = 1'b0;
    logic              done = 1'b0;
    logic [NCELL-1:0]  hold;
    logic              wr_sel;
    logic              rd_sel;
    logic              req;
    logic [TS_W-1:0]   conv_ts;
    logic              full;
    logic [LOST_W-1:0] lost;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cell_fifo_mgr #(.NCELL(NCELL), .TS_W(TS_W), .LOST_W(LOST_W)) i_cell_fifo_mgr (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .ts_gray_i   (ts_gray),
        .conv_ack_i  (ack),
        .conv_done_i (done),
        .hold_o      (hold),
        .wr_sel_o    (wr_sel),
        .rd_sel_o    (rd_sel),
        .conv_req_o  (req),
        .conv_ts_o   (conv_ts),
        .full_o      (full),
        .lost_o      (lost)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_ts(input int v);
        ts_gray = TS_W'(v ^ (v >> 1));
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        @(negedge clk);
    endtask

    // Converter model; optionally raises a trigger on the same edge as done.
    task automatic convert(input bit trig_with_done, output int got_ts, output int got_sel);
        int waited = 0;
        while (!req && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(req == 1'b1, "R6 request raised", int'(req), 1);
        got_ts  = int'(conv_ts);
        got_sel = int'(rd_sel);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(req == 1'b0, "R6 request drops after ack", int'(req), 0);
        repeat (2) @(negedge clk);
        check(hold[got_sel] == 1'b1, "R6 cell held while converting", int'(hold[got_sel]), 1);
        done = 1'b1;
        if (trig_with_done) trig = 1'b1;
        @(negedge clk);
        done = 1'b0;
        trig = 1'b0;
        if (!trig_with_done)
            check(hold[got_sel] == 1'b0, "R6 cell released after done", int'(hold[got_sel]), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int got_ts;
        int got_sel;
        repeat (3) @(negedge clk);
        check(hold == '0, "R1 hold", int'(hold), 0);
        check(full == 1'b0, "R1 full", int'(full), 0);
        check(req == 1'b0, "R1 req", int'(req), 0);
        check(lost == '0, "R1 lost", int'(lost), 0);
        check(wr_sel == 1'b0 && rd_sel == 1'b0, "R1 selects", int'({wr_sel, rd_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Every timestamp code, one hit and one conversion each.
        for (int v = 0; v < (1 << TS_W); v++) begin
            set_ts(v);
            check(int'(wr_sel) == v % 2, "R2 write select", int'(wr_sel), v % 2);
            pulse_trig();
            check(int'(hold) == (1 << (v % 2)), "R2 hold set", int'(hold), 1 << (v % 2));
            convert(1'b0, got_ts, got_sel);
            check(got_ts == v, "R4 captured timestamp", got_ts, v);
            check(got_sel == v % 2, "R5 read select", got_sel, v % 2);
            check(hold == '0, "R6 all released", int'(hold), 0);
        end

        // A held trigger counts once.
        set_ts(10);
        trig = 1'b1;
        repeat (8) @(negedge clk);
        trig = 1'b0;
        @(negedge clk);
        check($countones(hold) == 1, "R3 held trigger one hit", $countones(hold), 1);
        check(full == 1'b0, "R7 not full at one", int'(full), 0);

        set_ts(20);
        pulse_trig();
        check(full == 1'b1, "R7 full at two", int'(full), 1);
        check(hold == 2'b11, "R2 both held", int'(hold), 3);

        for (int k = 0; k < 5; k++) pulse_trig();
        check(lost == 3'd5, "R8 lost count", int'(lost), 5);
        check(hold == 2'b11 && wr_sel == 1'b0, "R8 drop leaves cells", int'({hold, wr_sel}), 6);
        for (int k = 0; k < 5; k++) pulse_trig();
        check(lost == 3'd7, "R8 lost saturates", int'(lost), 7);

        convert(1'b0, got_ts, got_sel);
        check(got_ts == 10 && got_sel == 0, "R5 oldest first", got_ts, 10);
        check(full == 1'b0, "R7 full clears", int'(full), 0);

        // Hit accepted on the same edge as a release.
        set_ts(30);
        convert(1'b1, got_ts, got_sel);
        check(got_ts == 20 && got_sel == 1, "R5 second cell", got_ts, 20);
        check(hold == 2'b01, "R9 swap of cells", int'(hold), 1);
        check(full == 1'b0, "R9 not full after swap", int'(full), 0);
        set_ts(40);
        pulse_trig();
        check(full == 1'b1, "R9 count intact", int'(full), 1);

        convert(1'b0, got_ts, got_sel);
        check(got_ts == 30 && got_sel == 0, "R5 third hit", got_ts, 30);
        convert(1'b0, got_ts, got_sel);
        check(got_ts == 40 && got_sel == 1, "R5 fourth hit", got_ts, 40);
        check(hold == '0 && full == 1'b0, "R7 empty at end", int'({hold, full}), 0);
        check(lost == 3'd7, "R8 lost held", int'(lost), 7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule